// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block moves a processor-style system from its normal run state into one of three low-power states and back again. Software first loads a two-bit mode and a six-bit qualification count, plus a mask of which of the 32 port lines may act as wake sources. It then raises an idle request. The block enters the state that the mode selects and gates the oscillator, the CPU clock and the system clock output to suit that state.

While the system sleeps, the block watches a set of active-low exit sources. Which of them are honoured depends on the state. Port wake lines are not taken at once. A selected line must be held low for a programmed number of oscillator cycles before the block counts it as a wake. In the deepest state the oscillator is stopped, so a selected line that goes low turns the oscillator back on without waiting for a clock. Qualification then runs on the restarted clock.

An asynchronous reset always returns the block to run with every clock enabled. A one-cycle completion pulse marks each return to run from a low-power state.

Top module: `lowpower_seq`

## Requirements
- R1: After reset, `lpState` reads 0 (RUN), `oscEn`, `cpuClkEn` and `sysClkEn` are all 1, and `wakeDone` is 0.
- R2: An `idleReq` sampled high in RUN moves `lpState` at that edge according to the stored mode. Mode 00 gives 1 (IDLE), 01 gives 2 (STANDBY), and 10 or 11 give 3 (HALT).
- R3: In RUN and IDLE all three clock enables are 1. In STANDBY `oscEn` is 1 and `cpuClkEn`/`sysClkEn` are 0. In HALT all three are 0 while no selected port line is low.
- R4: In IDLE, a low `intN` or `nmiN` at an edge returns to RUN. A low `wdIntN`, a low `dbgWakeN` or a selected port line held low leaves the state unchanged.
- R5: In STANDBY, a low `wdIntN`, `dbgWakeN` or `nmiN` at an edge returns to RUN. A low `intN` has no effect.
- R6: In HALT, a low `dbgWakeN` or `nmiN` at an edge returns to RUN. A low `wdIntN` or `intN` has no effect.
- R7: In STANDBY or HALT with qualification count N, a selected port line held low for N+2 consecutive edges returns to RUN at the (N+2)th edge. A shorter low pulse leaves the low-power state unchanged.
- R8: Port lines whose bit in the wake-select mask is 0 never cause a wake and never enable the oscillator.
- R9: In HALT, `oscEn` follows combinationally whether any selected port line is low. It rises with no clock edge and falls again when the line is released without qualifying.
- R10: `wakeDone` is 1 for exactly the one cycle after each edge that returns a low-power state to RUN. It is 0 at entry and at all other times.
- R11: Driving `rstN` low in any state forces RUN and all clock enables to 1 without a clock edge, and clears the stored mode to 00.
- R12: `idleReq` while already in a low-power state is ignored, and so are mode writes made there. The state stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock standing in for the oscillator |
| rstN | input | 1 | Asynchronous active-low reset, also an exit source |
| ctlWr | input | 1 | Write strobe for the mode and qualification count |
| ctlMode | input | 2 | Low-power mode to store |
| ctlQual | input | 6 | Qualification count N to store |
| selWr | input | 1 | Write strobe for the wake-select mask |
| selData | input | 32 | Wake-select mask, bit i enables port line i |
| idleReq | input | 1 | Request to enter the stored low-power mode |
| intN | input | 1 | Active-low OR of enabled interrupts |
| nmiN | input | 1 | Active-low non-maskable interrupt |
| wdIntN | input | 1 | Active-low watchdog interrupt |
| dbgWakeN | input | 1 | Active-low debugger wake request |
| portN | input | 32 | Active-low port wake lines |
| oscEn | output | 1 | Oscillator enable |
| cpuClkEn | output | 1 | CPU clock enable |
| sysClkEn | output | 1 | System clock output enable |
| lpState | output | 2 | Current state: 0 RUN, 1 IDLE, 2 STANDBY, 3 HALT |
| wakeDone | output | 1 | One-cycle pulse on return to RUN |

## Verification
A wrong state register shows at the ports within the same cycle, through `lpState` and the three clock enables. A qualification counter that is off by one shows up as a wake accepted one edge early or one edge late. The bench therefore sweeps pulse lengths from 1 to N+3 across several counts and lines, in both STANDBY and HALT. A wake source that is mis-gated shows up at the first edge after it is driven low, as a state that stays or leaves when it should not. A bad oscillator restart path in HALT shows on `oscEn` before any clock edge.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_STBY = 2'd2,
    ST_HALT = 2'd3
  } lpState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic qualRun;   // qualification counter may run
    logic gateCpu;   // CPU and system clock gated
    logic stopOsc;   // oscillator stopped unless a wake line restarts it
  } lpStrobe_t;

  function automatic lpState_e decodeMode(input logic [1:0] mode);
    if (mode[1])       return ST_HALT;
    else if (mode[0])  return ST_STBY;
    else               return ST_IDLE;
  endfunction

endpackage

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       idleReq,
  input  logic [1:0] modeReg,
  input  logic       intN,
  input  logic       nmiN,
  input  logic       wdIntN,
  input  logic       dbgWakeN,
  input  logic       qualOk,
  output lpState_e   stateQ,
  output lpStrobe_t  strobe,
  output logic       wakeDone
);

  lpState_e stateD;
  logic     exitNow;

  // which sources are legal depends on the current state
  always_comb begin
    exitNow = 1'b0;
    unique case (stateQ)
      ST_IDLE: exitNow = !intN || !nmiN;
      ST_STBY: exitNow = !wdIntN || !dbgWakeN || !nmiN || qualOk;
      ST_HALT: exitNow = !dbgWakeN || !nmiN || qualOk;
      default: exitNow = 1'b0;
    endcase
  end

  always_comb begin
    stateD = stateQ;
    if (stateQ == ST_RUN) begin
      if (idleReq) stateD = decodeMode(modeReg);
    end else if (exitNow) begin
      stateD = ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_RUN;
      wakeDone <= 1'b0;
    end else begin
      stateQ   <= stateD;
      wakeDone <= (stateQ != ST_RUN) && exitNow;
    end
  end

  always_comb begin
    strobe.qualRun = (stateQ == ST_STBY) || (stateQ == ST_HALT);
    strobe.gateCpu = (stateQ == ST_STBY) || (stateQ == ST_HALT);
    strobe.stopOsc = (stateQ == ST_HALT);
  end

endmodule

// File: rtl/lps_datapath.sv
module lps_datapath
  import lps_pkg::*;
#(
  parameter int PORTS  = 32,
  parameter int QUAL_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWr,
  input  logic [1:0]        ctlMode,
  input  logic [QUAL_W-1:0] ctlQual,
  input  logic              selWr,
  input  logic [PORTS-1:0]  selData,
  input  logic [PORTS-1:0]  portN,
  input  lpStrobe_t         strobe,
  input  logic              inRun,
  output logic [1:0]        modeReg,
  output logic              qualOk,
  output logic              anySelLow,
  output logic              oscEn,
  output logic              cpuClkEn,
  output logic              sysClkEn
);

  localparam int CNT_W = QUAL_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [QUAL_W-1:0] qualReg;
  logic [PORTS-1:0]  selReg;
  logic [PORTS-1:0]  lowHit;
  logic [CNT_W-1:0]  qualCnt;
  logic [CNT_W-1:0]  qualTarget;

  // configuration is only taken while running
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= 2'b00;
      qualReg <= '0;
      selReg  <= '0;
    end else begin
      if (ctlWr && inRun) begin
        modeReg <= ctlMode;
        qualReg <= ctlQual;
      end
      if (selWr) selReg <= selData;
    end
  end

  for (genvar i = 0; i < PORTS; i++) begin : g_mask
    assign lowHit[i] = selReg[i] & ~portN[i];
  end

  assign anySelLow  = |lowHit;
  assign qualTarget = CNT_W'(qualReg) + CNT_W'(1);

  // consecutive low samples of the OR of selected lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualCnt <= '0;
    end else if (!strobe.qualRun || !anySelLow) begin
      qualCnt <= '0;
    end else if (oscEn && qualCnt != CNT_MAX) begin
      qualCnt <= qualCnt + CNT_W'(1);
    end
  end

  assign qualOk   = strobe.qualRun && anySelLow && oscEn && (qualCnt == qualTarget);

  // a selected low line restarts the oscillator without a clock
  assign oscEn    = !strobe.stopOsc || anySelLow;
  assign cpuClkEn = !strobe.gateCpu;
  assign sysClkEn = !strobe.gateCpu;

endmodule

// File: rtl/lowpower_seq.sv
module lowpower_seq
  import lps_pkg::*;
#(
  parameter int PORTS  = 32,
  parameter int QUAL_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWr,
  input  logic [1:0]        ctlMode,
  input  logic [QUAL_W-1:0] ctlQual,
  input  logic              selWr,
  input  logic [PORTS-1:0]  selData,
  input  logic              idleReq,
  input  logic              intN,
  input  logic              nmiN,
  input  logic              wdIntN,
  input  logic              dbgWakeN,
  input  logic [PORTS-1:0]  portN,
  output logic              oscEn,
  output logic              cpuClkEn,
  output logic              sysClkEn,
  output logic [1:0]        lpState,
  output logic              wakeDone
);

  lpState_e  stateQ;
  lpStrobe_t strobe;
  logic [1:0] modeReg;
  logic       qualOk;
  logic       anySelLow;

  lps_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .idleReq  (idleReq),
    .modeReg  (modeReg),
    .intN     (intN),
    .nmiN     (nmiN),
    .wdIntN   (wdIntN),
    .dbgWakeN (dbgWakeN),
    .qualOk   (qualOk),
    .stateQ   (stateQ),
    .strobe   (strobe),
    .wakeDone (wakeDone)
  );

  lps_datapath #(.PORTS(PORTS), .QUAL_W(QUAL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctlWr     (ctlWr),
    .ctlMode   (ctlMode),
    .ctlQual   (ctlQual),
    .selWr     (selWr),
    .selData   (selData),
    .portN     (portN),
    .strobe    (strobe),
    .inRun     (stateQ == ST_RUN),
    .modeReg   (modeReg),
    .qualOk    (qualOk),
    .anySelLow (anySelLow),
    .oscEn     (oscEn),
    .cpuClkEn  (cpuClkEn),
    .sysClkEn  (sysClkEn)
  );

  assign lpState = stateQ;

endmodule

// File: rtl/lowpower_seq_chk.sv
module lowpower_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       idleReq,
  input logic       intN,
  input logic       nmiN,
  input logic [1:0] lpState,
  input logic       oscEn,
  input logic       cpuClkEn,
  input logic       sysClkEn,
  input logic       wakeDone,
  input logic       anySelLow
);

  // R2
  enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lpState == 2'd0 && idleReq) |=> (lpState != 2'd0));

  // R3
  standby_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lpState == 2'd2) |-> (oscEn && !cpuClkEn && !sysClkEn));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lpState == 2'd1 && intN && nmiN) |=> (lpState == 2'd1));

  // R9
  halt_osc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lpState == 2'd3) |-> (oscEn == anySelLow));

  // R10
  wake_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeDone) |-> (lpState == 2'd0 && $past(lpState) != 2'd0));

  // R10
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeDone |=> !wakeDone);

endmodule

bind lowpower_seq lowpower_seq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .idleReq   (idleReq),
  .intN      (intN),
  .nmiN      (nmiN),
  .lpState   (lpState),
  .oscEn     (oscEn),
  .cpuClkEn  (cpuClkEn),
  .sysClkEn  (sysClkEn),
  .wakeDone  (wakeDone),
  .anySelLow (anySelLow)
);

// File: tb/sim_lowpower_seq.sv
`timescale 1ns/1ps
module sim_lowpower_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWr = 1'b0;
  logic [1:0]  ctlMode = 2'b00;
  logic [5:0]  ctlQual = 6'd0;
  logic        selWr = 1'b0;
  logic [31:0] selData = '0;
  logic        idleReq = 1'b0;
  logic        intN = 1'b1, nmiN = 1'b1, wdIntN = 1'b1, dbgWakeN = 1'b1;
  logic [31:0] portN = '1;
  logic        oscEn, cpuClkEn, sysClkEn, wakeDone;
  logic [1:0]  lpState;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lowpower_seq u0 (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .ctlMode(ctlMode), .ctlQual(ctlQual),
    .selWr(selWr), .selData(selData), .idleReq(idleReq), .intN(intN), .nmiN(nmiN),
    .wdIntN(wdIntN), .dbgWakeN(dbgWakeN), .portN(portN), .oscEn(oscEn),
    .cpuClkEn(cpuClkEn), .sysClkEn(sysClkEn), .lpState(lpState), .wakeDone(wakeDone)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic setSel(input logic [31:0] m);
    selWr = 1'b1; selData = m; tick(); selWr = 1'b0;
  endtask

  task automatic enterMode(input logic [1:0] m, input logic [5:0] n);
    ctlWr = 1'b1; ctlMode = m; ctlQual = n; tick(); ctlWr = 1'b0;
    idleReq = 1'b1; tick(); idleReq = 1'b0;
  endtask

  task automatic nmiExit();
    nmiN = 1'b0; tick(); nmiN = 1'b1; tick();
  endtask

  function automatic logic [1:0] expState(input logic [1:0] m);
    return m[1] ? 2'd3 : (m[0] ? 2'd2 : 2'd1);
  endfunction

  initial begin
    #500000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    // R1 reset state
    chk("R1 state", lpState, 0);
    chk("R1 clocks", {oscEn, cpuClkEn, sysClkEn}, 3'b111);
    chk("R1 wakeDone", wakeDone, 0);
    #10 rstN = 1'b1;
    tick();
    chk("R1 state after release", lpState, 0);

    // R2/R3/R10 every mode code
    for (int m = 0; m < 4; m++) begin
      enterMode(2'(m), 6'd0);
      chk("R2 decode", lpState, expState(2'(m)));
      chk("R10 no pulse on entry", wakeDone, 0);
      case (expState(2'(m)))
        2'd1: chk("R3 idle clocks", {oscEn, cpuClkEn, sysClkEn}, 3'b111);
        2'd2: chk("R3 standby clocks", {oscEn, cpuClkEn, sysClkEn}, 3'b100);
        default: chk("R3 halt clocks", {oscEn, cpuClkEn, sysClkEn}, 3'b000);
      endcase
      nmiN = 1'b0; tick(); nmiN = 1'b1;
      chk("R10 wake state", lpState, 0);
      chk("R10 pulse", wakeDone, 1);
      chk("R3 run clocks", {oscEn, cpuClkEn, sysClkEn}, 3'b111);
      tick();
      chk("R10 pulse ends", wakeDone, 0);
    end

    // R12 idle request and mode write while asleep
    enterMode(2'b01, 6'd0);
    ctlWr = 1'b1; ctlMode = 2'b00; tick(); ctlWr = 1'b0;
    idleReq = 1'b1; tick(); tick(); idleReq = 1'b0;
    chk("R12 stays standby", lpState, 2);
    nmiExit();
    idleReq = 1'b1; tick(); idleReq = 1'b0;
    chk("R12 mode kept", lpState, 2);
    nmiExit();

    // R4 idle sources
    setSel(32'h0000_0010);
    enterMode(2'b00, 6'd0);
    wdIntN = 1'b0; tick(); wdIntN = 1'b1;
    chk("R4 wd ignored", lpState, 1);
    dbgWakeN = 1'b0; tick(); dbgWakeN = 1'b1;
    chk("R4 dbg ignored", lpState, 1);
    portN[4] = 1'b0; repeat (5) tick(); portN[4] = 1'b1;
    chk("R4 port ignored", lpState, 1);
    intN = 1'b0; tick(); intN = 1'b1;
    chk("R4 int exits", lpState, 0);
    tick();

    // R5 standby sources
    enterMode(2'b01, 6'd0);
    intN = 1'b0; tick(); intN = 1'b1;
    chk("R5 int ignored", lpState, 2);
    wdIntN = 1'b0; tick(); wdIntN = 1'b1;
    chk("R5 wd exits", lpState, 0);
    tick();
    enterMode(2'b01, 6'd0);
    dbgWakeN = 1'b0; tick(); dbgWakeN = 1'b1;
    chk("R5 dbg exits", lpState, 0);
    tick();

    // R6 halt sources
    enterMode(2'b10, 6'd0);
    wdIntN = 1'b0; tick(); wdIntN = 1'b1;
    chk("R6 wd ignored", lpState, 3);
    intN = 1'b0; tick(); intN = 1'b1;
    chk("R6 int ignored", lpState, 3);
    dbgWakeN = 1'b0; tick(); dbgWakeN = 1'b1;
    chk("R6 dbg exits", lpState, 0);
    tick();

    // R8 unselected lines
    setSel(32'h0000_0020);
    enterMode(2'b01, 6'd0);
    portN[3] = 1'b0; repeat (6) tick();
    chk("R8 standby unselected", lpState, 2);
    portN[3] = 1'b1; nmiExit();
    enterMode(2'b11, 6'd0);
    portN = 32'h0000_0020 ^ 32'hFFFF_FFFF ^ 32'h0000_0020; // no change
    portN[7] = 1'b0; #1;
    chk("R8 osc stays off", oscEn, 0);
    repeat (6) tick();
    chk("R8 halt unselected", lpState, 3);
    portN[7] = 1'b1; nmiExit();

    // R7/R9 sweep of counts, lengths, lines and modes
    for (int ni = 0; ni < 4; ni++) begin
      int n;
      n = (ni == 0) ? 0 : (ni == 1) ? 1 : (ni == 2) ? 3 : 6;
      for (int md = 1; md <= 2; md++) begin
        for (int len = 1; len <= n + 3; len++) begin
          int k;
          bit woke;
          k = (n * 7 + len * 3 + md) % 32;
          setSel(32'd1 << k);
          enterMode(2'(md), 6'(n));
          woke = 1'b0;
          portN[k] = 1'b0;
          #1;
          if (md == 2) chk("R9 osc restarts", oscEn, 1);
          for (int e = 1; e <= len; e++) begin
            tick();
            if (!woke) begin
              if (e == n + 2) begin
                chk("R7 qualified wake", lpState, 0);
                chk("R10 pulse on port wake", wakeDone, 1);
                woke = 1'b1;
              end else begin
                chk("R7 not yet", lpState, (md == 1) ? 2 : 3);
              end
            end
          end
          portN[k] = 1'b1;
          #1;
          if (!woke) begin
            if (md == 2) chk("R9 osc stops again", oscEn, 0);
            tick();
            chk("R7 short pulse stays", lpState, (md == 1) ? 2 : 3);
            nmiExit();
          end else begin
            tick();
          end
        end
      end
    end

    // R11 asynchronous reset from a sleep state
    setSel(32'h0);
    enterMode(2'b11, 6'd2);
    chk("R11 in halt", lpState, 3);
    #1 rstN = 1'b0;
    #0.5;
    chk("R11 async state", lpState, 0);
    chk("R11 async clocks", {oscEn, cpuClkEn, sysClkEn}, 3'b111);
    tick();
    rstN = 1'b1;
    tick();
    idleReq = 1'b1; tick(); idleReq = 1'b0;
    chk("R11 mode cleared", lpState, 1);
    intN = 1'b0; tick(); intN = 1'b1;
    tick();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule